// File: doc/BRIEF.md
# Configurable Multilevel Pipeline Register

This block keeps four data registers, called A1, A2, B1 and B2, that a 2-bit instruction code reconfigures on every rising clock edge. The same storage works either as one four-stage delay line (input into A1, then A2, then B1, then B2) or as two independent two-stage pipelines, the A pair and the B pair, each loaded from the shared data input. A fourth instruction freezes all of the storage. It is meant for short-term holding of operands or for adding a chosen number of cycles of delay in a datapath.

Any one of the four registers can be read at the output through a 2-bit select. The read path is combinational, so the output follows a new select without waiting for a clock edge. An active-low enable qualifies the output. When the enable is off, the data output is forced to zero and the valid flag drops. This replaces a three-state driver inside the chip. A compile-time parameter picks how a pair load behaves. In push-through mode, loading the first stage of a pair moves its old value into the second stage. In overwrite mode, the load only replaces the first stage.

Top module: `mlp_top`

## Requirements
- R1: A clock edge with `rst_n` low clears all four registers to zero, whatever the instruction.
- R2: Instruction 0 shifts in a single chain: A1 takes `d`, A2 takes old A1, B1 takes old A2, and B2 takes old B1. The old value of B2 is lost.
- R3: Instruction 3 leaves all four registers unchanged.
- R4: Instruction 2 loads `d` into A1. With `PUSH_THROUGH`=1, A2 takes the old A1 on the same edge. B1 and B2 do not change.
- R5: Instruction 1 loads `d` into B1. With `PUSH_THROUGH`=1, B2 takes the old B1 on the same edge. A1 and A2 do not change.
- R6: With `PUSH_THROUGH`=0, instructions 1 and 2 change only the first stage of the addressed pair. Second stages change only through instruction 0.
- R7: While the output is enabled, `y` shows the register chosen by `sel`: 0 selects B2, 1 selects B1, 2 selects A2 and 3 selects A1. `y_vld` is 1.
- R8: A change of `sel` shows on `y` within the same clock period, without any clock edge.
- R9: While `oe_n` is 1, `y_vld` is 0 and `y` is all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; storage updates on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| instr | input | 2 | 0 chain shift, 1 load B pair, 2 load A pair, 3 hold |
| d | input | W | Data loaded into the first stage addressed |
| sel | input | 2 | Output register select (0 B2, 1 B1, 2 A2, 3 A1) |
| oe_n | input | 1 | Output enable, active low |
| y | output | W | Selected register value, zero when disabled |
| y_vld | output | 1 | High when `y` carries register data |

## Verification
Two things can happen on the same edge in push-through mode: the first stage of a pair captures new input, and its previous value moves into the second stage. A wrong order would copy the new data into both stages, or lose the old value. The bench drives back-to-back pair loads with distinct data, interleaved with chain shifts and holds. It reads all four registers in every cycle, comparing against separate reference models for both parameter settings. The second overlap is between a storage update and a select change in the same period. The bench changes `sel` several times between edges and judges that each value appears at once, and that reading does not disturb the stored contents.

// File: rtl/mlp_pkg.sv
// Package: shared encodings of the multilevel pipeline register.
// Assumes register slots are numbered in shift order, A1 first.
package mlp_pkg;

    typedef enum logic [1:0] {
        OP_SHIFT = 2'd0,
        OP_LD_B  = 2'd1,
        OP_LD_A  = 2'd2,
        OP_HOLD  = 2'd3
    } mlp_op_e;

    localparam int NREG   = 4;
    localparam int IDX_A1 = 0;
    localparam int IDX_A2 = 1;
    localparam int IDX_B1 = 2;
    localparam int IDX_B2 = 3;

endpackage

// File: rtl/mlp_store.sv
// Module: four-register storage bank with instruction decode.
// Assumes: instr is sampled on the rising edge; the reset is synchronous, active low.
// PUSH_THROUGH picks whether a pair load also advances that pair's second stage.
module mlp_store #(
    parameter int W            = 8,
    parameter bit PUSH_THROUGH = 1'b1
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [1:0]                      instr,
    input  logic [W-1:0]                    d,
    output logic [mlp_pkg::NREG-1:0][W-1:0] bank
);
    import mlp_pkg::*;

    mlp_op_e                 op;
    logic [NREG-1:0][W-1:0]  bank_nxt;
    logic                    adv_a2;
    logic                    adv_b2;

    assign op = mlp_op_e'(instr);

    // Variant choice: whether a pair load moves the old first stage down.
    generate
        if (PUSH_THROUGH) begin : g_push
            assign adv_a2 = (op == OP_LD_A);
            assign adv_b2 = (op == OP_LD_B);
        end else begin : g_ovwr
            assign adv_a2 = 1'b0;
            assign adv_b2 = 1'b0;
        end
    endgenerate

    // Next-state selection for every register slot.
    always_comb begin
        bank_nxt = bank;
        unique case (op)
            OP_SHIFT: begin
                bank_nxt[IDX_A1] = d;
                bank_nxt[IDX_A2] = bank[IDX_A1];
                bank_nxt[IDX_B1] = bank[IDX_A2];
                bank_nxt[IDX_B2] = bank[IDX_B1];
            end
            OP_LD_A: begin
                bank_nxt[IDX_A1] = d;
                if (adv_a2) bank_nxt[IDX_A2] = bank[IDX_A1];
            end
            OP_LD_B: begin
                bank_nxt[IDX_B1] = d;
                if (adv_b2) bank_nxt[IDX_B2] = bank[IDX_B1];
            end
            OP_HOLD: bank_nxt = bank;
            default: bank_nxt = bank;
        endcase
    end

    // Storage update with synchronous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) bank <= '0;
        else        bank <= bank_nxt;
    end

endmodule

// File: rtl/mlp_outmux.sv
// Module: combinational read-out of one register, qualified by an active-low enable.
// Assumes: the select encoding is 0 B2, 1 B1, 2 A2, 3 A1; a disabled output reads as zero.
module mlp_outmux #(
    parameter int W = 8
) (
    input  logic [mlp_pkg::NREG-1:0][W-1:0] bank,
    input  logic [1:0]                      sel,
    input  logic                            oe_n,
    output logic [W-1:0]                    y,
    output logic                            y_vld
);
    import mlp_pkg::*;

    logic [W-1:0] picked;

    // Register choice from the select code.
    always_comb begin
        unique case (sel)
            2'd0:    picked = bank[IDX_B2];
            2'd1:    picked = bank[IDX_B1];
            2'd2:    picked = bank[IDX_A2];
            default: picked = bank[IDX_A1];
        endcase
    end

    // Enable gating in place of a three-state driver.
    always_comb begin
        y_vld = ~oe_n;
        y     = oe_n ? '0 : picked;
    end

endmodule

// File: rtl/mlp_top.sv
// Module: multilevel pipeline register top, storage plus output selector.
// Assumes a single clock domain and a synchronous active-low reset.
module mlp_top #(
    parameter int W            = 8,
    parameter bit PUSH_THROUGH = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [1:0]   instr,
    input  logic [W-1:0] d,
    input  logic [1:0]   sel,
    input  logic         oe_n,
    output logic [W-1:0] y,
    output logic         y_vld
);
    logic [mlp_pkg::NREG-1:0][W-1:0] bank_q;

    mlp_store #(.W(W), .PUSH_THROUGH(PUSH_THROUGH)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .instr (instr),
        .d     (d),
        .bank  (bank_q)
    );

    mlp_outmux #(.W(W)) u_outmux (
        .bank  (bank_q),
        .sel   (sel),
        .oe_n  (oe_n),
        .y     (y),
        .y_vld (y_vld)
    );

endmodule

// File: rtl/mlp_chk.sv
// Checker: timing properties of the multilevel pipeline register, bound to mlp_top.
module mlp_chk #(
    parameter int W            = 8,
    parameter bit PUSH_THROUGH = 1'b1
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic [1:0]                      instr,
    input logic [W-1:0]                    d,
    input logic [1:0]                      sel,
    input logic                            oe_n,
    input logic [W-1:0]                    y,
    input logic                            y_vld,
    input logic [mlp_pkg::NREG-1:0][W-1:0] bank
);
    import mlp_pkg::*;

    // R2
    chain_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (instr == 2'd0) |=> (bank[IDX_A1] == $past(d)) && (bank[IDX_A2] == $past(bank[IDX_A1]))
                         && (bank[IDX_B1] == $past(bank[IDX_A2])) && (bank[IDX_B2] == $past(bank[IDX_B1])));

    // R3
    hold_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (instr == 2'd3) |=> $stable(bank));

    // R4
    load_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (instr == 2'd2) |=> (bank[IDX_A1] == $past(d)) && $stable(bank[IDX_B1]) && $stable(bank[IDX_B2])
                         && (bank[IDX_A2] == (PUSH_THROUGH ? $past(bank[IDX_A1]) : $past(bank[IDX_A2]))));

    // R5
    load_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (instr == 2'd1) |=> (bank[IDX_B1] == $past(d)) && $stable(bank[IDX_A1]) && $stable(bank[IDX_A2])
                         && (bank[IDX_B2] == (PUSH_THROUGH ? $past(bank[IDX_B1]) : $past(bank[IDX_B2]))));

    // R7
    read_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_n |-> y_vld && (y == bank[3 - int'(sel)]));

    // R9
    disabled_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !y_vld && (y == '0));

endmodule

bind mlp_top mlp_chk #(.W(W), .PUSH_THROUGH(PUSH_THROUGH)) u_mlp_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .instr (instr),
    .d     (d),
    .sel   (sel),
    .oe_n  (oe_n),
    .y     (y),
    .y_vld (y_vld),
    .bank  (bank_q)
);

// File: tb/test_mlp_top.sv
// Bench: drives both parameter variants with shared stimulus and compares against reference models.
module test_mlp_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] instr = 2'd3;
    logic [7:0] d = 8'h00;
    logic [1:0] sel = 2'd0;
    logic       oe_n = 1'b0;
    logic [7:0] y_p, y_o;
    logic       v_p, v_o;

    int n_chk = 0;
    int n_fail = 0;

    // Reference state, slot 0 = A1, 1 = A2, 2 = B1, 3 = B2.
    logic [7:0] mp [4];
    logic [7:0] mo [4];

    always #10 clk = ~clk;

    mlp_top #(.W(8), .PUSH_THROUGH(1'b1)) i_mlp_top (
        .clk(clk), .rst_n(rst_n), .instr(instr), .d(d), .sel(sel), .oe_n(oe_n), .y(y_p), .y_vld(v_p));

    mlp_top #(.W(8), .PUSH_THROUGH(1'b0)) i_mlp_top_ow (
        .clk(clk), .rst_n(rst_n), .instr(instr), .d(d), .sel(sel), .oe_n(oe_n), .y(y_o), .y_vld(v_o));

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic string op_tag(int op, bit push, bit rst);
        if (!rst) return "R1";
        case (op)
            0: return "R2";
            3: return "R3";
            2: return push ? "R4" : "R6";
            default: return push ? "R5" : "R6";
        endcase
    endfunction

    // One clock period: drive, update the models at the edge, then read every slot.
    task automatic step(int op, logic [7:0] data, bit oe_off, bit rst);
        @(negedge clk);
        instr = op[1:0];
        d     = data;
        rst_n = rst;
        oe_n  = oe_off;
        @(posedge clk);
        if (!rst) begin
            for (int k = 0; k < 4; k++) begin mp[k] = 8'h00; mo[k] = 8'h00; end
        end else begin
            case (op)
                0: begin
                    for (int k = 3; k > 0; k--) begin mp[k] = mp[k-1]; mo[k] = mo[k-1]; end
                    mp[0] = data; mo[0] = data;
                end
                1: begin mp[3] = mp[2]; mp[2] = data; mo[2] = data; end
                2: begin mp[1] = mp[0]; mp[0] = data; mo[0] = data; end
                default: ;
            endcase
        end
        #2;
        for (int s = 0; s < 4; s++) begin
            sel = s[1:0];
            #1;
            if (!oe_off) begin
                chk($sformatf("R7/%s push", op_tag(op, 1'b1, rst)), y_p, mp[3-s]);
                chk($sformatf("R7/%s ovwr", op_tag(op, 1'b0, rst)), y_o, mo[3-s]);
                chk("R7 valid", {7'd0, v_p & v_o}, 8'd1);
            end else begin
                chk("R9 data", y_p | y_o, 8'h00);
                chk("R9 valid", {7'd0, v_p | v_o}, 8'd0);
            end
        end
        if (!oe_off) begin
            // R8: select moves between edges, output follows immediately
            sel = 2'd3; #1;
            chk("R8 push", y_p, mp[0]);
            sel = 2'd0; #1;
            chk("R8 ovwr", y_o, mo[3]);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog all requirements actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int k = 0; k < 4; k++) begin mp[k] = 8'h00; mo[k] = 8'h00; end
        // R1: reset wins over a load instruction
        step(2, 8'hAA, 1'b0, 1'b0);
        step(0, 8'h55, 1'b0, 1'b0);
        // Directed pair loads: push order and overwrite isolation (R4, R5, R6)
        step(2, 8'h11, 1'b0, 1'b1);
        step(2, 8'h22, 1'b0, 1'b1);
        step(1, 8'h33, 1'b0, 1'b1);
        step(1, 8'h44, 1'b0, 1'b1);
        step(3, 8'h99, 1'b0, 1'b1);
        step(0, 8'h66, 1'b0, 1'b1);
        // Sweep of instruction sequences, data, enable and a mid-run reset
        for (int c = 0; c < 400; c++) begin
            step((c * 7 + c / 5) % 4, 8'((c * 37 + 5) % 256), (c % 11) == 10, c != 200);
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule